// File: doc/BRIEF.md
# Round-Robin Sealer Slot Checker

This block keeps the local notion of time for a permissioned chain in which a fixed set of authorities seal blocks in turn. A free-running tick input is divided into steps of a programmable number of ticks. The authority scheduled for a step is the entry at position (step mod N) of an authority table. That position advances with the step counter and wraps to the first entry after the last. The table is captured while reset is held.

Candidate blocks arrive on a valid/ready stream. Each carries the step it claims and the identifier of the node that sealed it. For each candidate, the block returns one verdict on a second valid/ready stream:
- a block claiming a step more than one beyond the local step is rejected as premature;
- a block whose step is not newer than the last accepted block is rejected as stale or duplicate;
- a block sealed by a node other than the one scheduled for its step is rejected as out of turn;
- any other block is accepted.

An authority that stays silent does not stall the chain. Its step passes, and a later scheduled authority's block is still accepted, so the chain only shows a longer gap. A local node can compare its own identifier against the schedule through a "may seal" flag.

The candidate stream is back-pressured by the verdict stream. The block holds one verdict. `blk_ready` is high only when no verdict is pending, or when the pending verdict is consumed in the same cycle. A verdict stays stable while `res_ready` is low.

Top module: `slot_rotation_checker`

## Requirements
- R1: After reset, `cur_step` is 0, `res_valid` is 0, and `exp_sealer` equals table entry 0.
- R2: `cur_step` advances by exactly 1 each time `step_len` ticks have been counted. A `step_len` of 0 behaves as 1.
- R3: `exp_sealer` is table entry (`cur_step` mod N) and wraps back to entry 0 after entry N-1. Entry k occupies bits [k*ID_W +: ID_W] of `auth_list`.
- R4: A candidate with `blk_step` greater than `cur_step`+1 gets verdict code 1 (premature) and is not accepted. A candidate with `blk_step` equal to `cur_step`+1 is not premature.
- R5: When a block has already been accepted, a candidate with `blk_step` less than or equal to the last accepted step gets code 3 (stale/duplicate).
- R6: A candidate whose `blk_sealer` differs from table entry (`blk_step` mod N) gets code 2 (out of turn).
- R7: A candidate that fails none of the checks gets code 0 with `res_accept` high. When several checks fail, the code is chosen with priority premature, then stale, then out of turn.
- R8: Steps in which no block arrives do not prevent acceptance of a later step's block from its scheduled sealer.
- R9: `may_seal` is high exactly when `local_id` equals `exp_sealer` and no block has been accepted for the current step or a later step.
- R10: The verdict appears with `res_valid` one cycle after the candidate handshake. `blk_ready` is low while a verdict is pending and `res_ready` is low. A pending verdict is held stable until consumed.
- R11: `auth_list` is sampled only during reset. Later changes on it have no effect on `exp_sealer` or on verdicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; authority table loads while low |
| tick | input | 1 | One time tick per cycle it is high |
| step_len | input | LEN_W | Ticks per step (0 treated as 1) |
| auth_list | input | N_AUTH*ID_W | Authority identifiers, entry k at bits [k*ID_W +: ID_W] |
| blk_valid | input | 1 | Candidate block valid |
| blk_ready | output | 1 | Candidate block ready |
| blk_step | input | STEP_W | Step claimed by the candidate |
| blk_sealer | input | ID_W | Identifier of the candidate's sealer |
| res_valid | output | 1 | Verdict valid |
| res_ready | input | 1 | Verdict consumer ready |
| res_accept | output | 1 | Verdict: block accepted |
| res_reason | output | 2 | 0 accepted, 1 premature, 2 out of turn, 3 stale/duplicate |
| local_id | input | ID_W | Identifier of the local node |
| may_seal | output | 1 | Local node is scheduled and its step is still open |
| cur_step | output | STEP_W | Current step count |
| exp_sealer | output | ID_W | Identifier scheduled for the current step |

## Verification
The hardest case to reach is a step with no block at all, followed by a block two steps later. This needs the step counter moved precisely without any candidate in flight. The bench controls every tick pulse, skips a whole step, and then offers a wrong sealer and the right sealer for the later step.

The overlap of checks is set up on purpose: a premature candidate that also has a wrong sealer, and a stale candidate that also has a wrong sealer. A one-step-ahead block is accepted before the counter reaches its step, and the bench then confirms that `may_seal` stays low for that step. Back-pressure is exercised by holding `res_ready` low across several cycles after a handshake.

// File: rtl/slotchk_pkg.sv
package slotchk_pkg;
  typedef enum logic [1:0] {
    VERD_OK     = 2'd0,
    VERD_FUTURE = 2'd1,
    VERD_WRONG  = 2'd2,
    VERD_STALE  = 2'd3
  } verdict_e;
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int STEP_W = 32,
  parameter int LEN_W  = 16,
  parameter int N_AUTH = 5,
  localparam int POS_W = (N_AUTH > 1) ? $clog2(N_AUTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [LEN_W-1:0]  step_len,
  output logic [STEP_W-1:0] step,
  output logic [POS_W-1:0]  pos
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W:0]   eff_len;
  logic             boundary;

  // zero-length steps are treated as one tick long
  assign eff_len  = (step_len == '0) ? (LEN_W+1)'(1) : {1'b0, step_len};
  assign boundary = ({1'b0, cnt} + (LEN_W+1)'(1)) >= eff_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      step <= '0;
      pos  <= '0;
    end else if (tick) begin
      if (boundary) begin
        cnt  <= '0;
        step <= step + STEP_W'(1);
        pos  <= (pos == POS_W'(N_AUTH-1)) ? '0 : pos + POS_W'(1);
      end else begin
        cnt <= cnt + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/auth_table.sv
module auth_table #(
  parameter int N_AUTH = 5,
  parameter int ID_W   = 8,
  parameter int STEP_W = 32,
  localparam int POS_W = (N_AUTH > 1) ? $clog2(N_AUTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_AUTH*ID_W-1:0] list_in,
  input  logic [POS_W-1:0]       cur_pos,
  input  logic [STEP_W-1:0]      blk_step,
  output logic [ID_W-1:0]        cur_id,
  output logic [ID_W-1:0]        blk_id
);
  logic [ID_W-1:0]   tbl [N_AUTH];
  logic [STEP_W-1:0] blk_mod;

  for (genvar g = 0; g < N_AUTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) tbl[g] <= list_in[g*ID_W +: ID_W];
    end
  end

  assign blk_mod = blk_step % STEP_W'(N_AUTH);

  always_comb begin
    cur_id = '0;
    blk_id = '0;
    for (int k = 0; k < N_AUTH; k++) begin
      if (cur_pos == POS_W'(k))  cur_id = tbl[k];
      if (blk_mod == STEP_W'(k)) blk_id = tbl[k];
    end
  end
endmodule

// File: rtl/slot_judge.sv
module slot_judge
  import slotchk_pkg::*;
#(
  parameter int STEP_W = 32,
  parameter int ID_W   = 8
) (
  input  logic [STEP_W-1:0] cur_step,
  input  logic [STEP_W-1:0] blk_step,
  input  logic [ID_W-1:0]   blk_sealer,
  input  logic [ID_W-1:0]   sched_id,
  input  logic              have_acc,
  input  logic [STEP_W-1:0] last_acc,
  output verdict_e          verdict
);
  logic future, stale, wrong;

  assign future = {1'b0, blk_step} > ({1'b0, cur_step} + (STEP_W+1)'(1));
  assign stale  = have_acc && (blk_step <= last_acc);
  assign wrong  = blk_sealer != sched_id;

  always_comb begin
    if (future)     verdict = VERD_FUTURE;
    else if (stale) verdict = VERD_STALE;
    else if (wrong) verdict = VERD_WRONG;
    else            verdict = VERD_OK;
  end
endmodule

// File: rtl/slot_rotation_checker.sv
module slot_rotation_checker
  import slotchk_pkg::*;
#(
  parameter int N_AUTH = 5,
  parameter int ID_W   = 8,
  parameter int STEP_W = 32,
  parameter int LEN_W  = 16,
  localparam int POS_W = (N_AUTH > 1) ? $clog2(N_AUTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [LEN_W-1:0]       step_len,
  input  logic [N_AUTH*ID_W-1:0] auth_list,
  input  logic                   blk_valid,
  output logic                   blk_ready,
  input  logic [STEP_W-1:0]      blk_step,
  input  logic [ID_W-1:0]        blk_sealer,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic                   res_accept,
  output logic [1:0]             res_reason,
  input  logic [ID_W-1:0]        local_id,
  output logic                   may_seal,
  output logic [STEP_W-1:0]      cur_step,
  output logic [ID_W-1:0]        exp_sealer
);
  logic [POS_W-1:0]  cur_pos;
  logic [ID_W-1:0]   blk_id;
  logic              have_acc;
  logic [STEP_W-1:0] last_acc;
  verdict_e          verdict;
  logic              fire;

  step_timer #(.STEP_W(STEP_W), .LEN_W(LEN_W), .N_AUTH(N_AUTH)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_len(step_len),
    .step(cur_step), .pos(cur_pos)
  );

  auth_table #(.N_AUTH(N_AUTH), .ID_W(ID_W), .STEP_W(STEP_W)) u_table (
    .clk(clk), .rst_n(rst_n), .list_in(auth_list), .cur_pos(cur_pos),
    .blk_step(blk_step), .cur_id(exp_sealer), .blk_id(blk_id)
  );

  slot_judge #(.STEP_W(STEP_W), .ID_W(ID_W)) u_judge (
    .cur_step(cur_step), .blk_step(blk_step), .blk_sealer(blk_sealer),
    .sched_id(blk_id), .have_acc(have_acc), .last_acc(last_acc),
    .verdict(verdict)
  );

  // single verdict slot: a new candidate is taken only when the slot drains
  assign blk_ready = !res_valid || res_ready;
  assign fire      = blk_valid && blk_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_reason <= 2'd0;
      have_acc   <= 1'b0;
      last_acc   <= '0;
    end else if (fire) begin
      res_valid  <= 1'b1;
      res_reason <= 2'(verdict);
      if (verdict == VERD_OK) begin
        have_acc <= 1'b1;
        last_acc <= blk_step;
      end
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assign res_accept = res_valid && (res_reason == 2'(VERD_OK));
  assign may_seal   = (local_id == exp_sealer) &&
                      !(have_acc && (last_acc >= cur_step));
endmodule

// File: rtl/slot_rotation_checker_sva.sv
module slot_rotation_checker_sva #(
  parameter int STEP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              blk_valid,
  input logic              blk_ready,
  input logic [STEP_W-1:0] blk_step,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_accept,
  input logic [1:0]        res_reason,
  input logic [STEP_W-1:0] cur_step,
  input logic              have_acc,
  input logic [STEP_W-1:0] last_acc
);
  a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_step != $past(cur_step)) |-> (cur_step == $past(cur_step) + STEP_W'(1)));

  a_r4_premature_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready &&
     ({1'b0, blk_step} > ({1'b0, cur_step} + (STEP_W+1)'(1))))
    |=> (res_valid && res_reason == 2'd1 && !res_accept));

  a_r5_stale_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_valid && blk_ready && have_acc && (blk_step <= last_acc))
    |=> (res_valid && res_reason == 2'd3));

  a_r10_verdict_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready)
    |=> (res_valid && $stable(res_reason) && $stable(res_accept)));

  a_r4_accepted_not_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    have_acc |-> ({1'b0, last_acc} <= ({1'b0, cur_step} + (STEP_W+1)'(1))));
endmodule

bind slot_rotation_checker slot_rotation_checker_sva #(.STEP_W(STEP_W)) u_sva (.*);

// File: tb/tb_slot_rotation_checker.sv
module tb_slot_rotation_checker;
  localparam int N  = 5;
  localparam int IW = 8;
  localparam int SW = 32;
  localparam int LW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [LW-1:0] step_len = LW'(3);
  logic [N*IW-1:0] auth_list;
  logic blk_valid = 1'b0;
  logic blk_ready;
  logic [SW-1:0] blk_step = '0;
  logic [IW-1:0] blk_sealer = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic res_accept;
  logic [1:0] res_reason;
  logic [IW-1:0] local_id = 8'd10;
  logic may_seal;
  logic [SW-1:0] cur_step;
  logic [IW-1:0] exp_sealer;

  int checks = 0;
  int errors = 0;
  logic [2:0] sb_q[$];
  string sb_tag[$];

  always #2 clk = ~clk;

  slot_rotation_checker #(.N_AUTH(N), .ID_W(IW), .STEP_W(SW), .LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_len(step_len),
    .auth_list(auth_list), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_step(blk_step), .blk_sealer(blk_sealer), .res_valid(res_valid),
    .res_ready(res_ready), .res_accept(res_accept), .res_reason(res_reason),
    .local_id(local_id), .may_seal(may_seal), .cur_step(cur_step),
    .exp_sealer(exp_sealer)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a verdict is consumed
  always @(negedge clk) begin
    if (rst_n && res_valid && res_ready) begin
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected verdict actual=%0d expected=none", res_reason);
      end else begin
        logic [2:0] e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        chk(t, {61'd0, res_accept, res_reason}, {61'd0, e});
      end
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic send(input logic [SW-1:0] s, input logic [IW-1:0] id,
                      input logic [1:0] code, input string tag);
    sb_q.push_back({code == 2'd0, code});
    sb_tag.push_back(tag);
    @(negedge clk);
    blk_valid = 1'b1; blk_step = s; blk_sealer = id;
    while (!blk_ready) @(negedge clk);
    @(negedge clk);
    blk_valid = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) auth_list[k*IW +: IW] = IW'(10 + k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 step", cur_step, 0);
    chk("R1 valid", res_valid, 0);
    chk("R1 sealer", exp_sealer, 10);
    chk("R9 open slot", may_seal, 1);
    auth_list = '1;                             // R11: ignored after reset

    send(0, 10, 2'd0, "R7 accept step0");
    chk("R9 closed after accept", may_seal, 0);
    send(0, 10, 2'd3, "R5 duplicate");
    send(2, 12, 2'd1, "R4 two ahead");
    send(1, 11, 2'd0, "R4 one ahead accepted");
    ticks(3);
    chk("R2 step1", cur_step, 1);
    chk("R3 sealer step1", exp_sealer, 11);
    local_id = 8'd11;
    @(negedge clk);
    chk("R9 early-filled step", may_seal, 0);

    ticks(6);                                   // step 2 left empty
    chk("R2 step3", cur_step, 3);
    send(3, 12, 2'd2, "R6 out of turn");
    send(3, 13, 2'd0, "R8 after gap");
    send(9, 99, 2'd1, "R7 premature over wrong");
    send(2, 99, 2'd3, "R7 stale over wrong");

    ticks(6);
    chk("R3 wrap", exp_sealer, 10);
    chk("R11 table kept", exp_sealer, 10);
    local_id = 8'd10;
    @(negedge clk);
    chk("R9 open at wrap", may_seal, 1);
    send(5, 10, 2'd0, "R11 verdict with latched table");
    chk("R9 closed", may_seal, 0);

    step_len = '0;
    ticks(2);
    chk("R2 zero length", cur_step, 7);
    step_len = LW'(3);

    res_ready = 1'b0;
    send(7, 12, 2'd0, "R10 held verdict");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 valid held", res_valid, 1);
      chk("R10 ready low", blk_ready, 0);
      chk("R10 code held", {res_accept, res_reason}, 3'b100);
    end
    res_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 drained", sb_q.size(), 0);
    chk("R10 idle", res_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule